// File: doc/BRIEF.md
# Double-Buffered LED Matrix Refresher

This block keeps an RGB LED matrix lit on its own, so the host only has to write pixel values. It stores two complete frames. The display side scans the front frame, and the host fills the back frame. For every matrix row the block reads one greyscale word per colour channel from its frame store. It shifts those words into a daisy chain of constant-current column drivers, each of which takes a 192-bit segment (16 channels of 12 bits). It then pulses a latch and moves the one-hot row select to the row it has just loaded.

The host swaps the two frames by pulsing a ready strobe once it has finished writing. The swap is held back until the last cycle of the frame being shown, so a frame is never built from both banks. A single mixed-radix counter paces all of this. Its upper field is the row and its lower fields are the channel, the bit and the shift-clock phase. The row and channel fields also form the read address. The whole matrix is blanked while the latch pulses and while the row select moves.

Top module: `led_matrix_refresh`

## Requirements
- R1: While reset is asserted, `sclk_o`, `latch_o` and `sdo_o` are 0 and `row_sel_o` is all zeros.
- R2: Each row period shifts exactly COLS*3*CH_BITS bits. The words go out channel 0 first and channel COLS*3-1 last, each word MSB first.
- R3: `latch_o` is high for exactly one clock, in the clock right after the high phase of the shift clock for the final bit of the row. There is one latch per row.
- R4: `blank_o` is high during the latch clock and the clock after it. `row_sel_o` changes only while `blank_o` is high.
- R5: `row_sel_o` is one-hot or zero. After the latch of row r it holds bit r set. Rows are shown in ascending order and wrap from ROWS-1 to 0.
- R6: Each bit takes two clocks, `sclk_o` low and then high. `sdo_o` is set during the low clock and held through the high clock, so the drivers sample it on the rising edge of `sclk_o`.
- R7: A pulse on `host_ready_i` swaps the front and back banks on the last clock of the current frame. Without a pulse, no swap happens. Rows still to be shown in the current frame come from the old front bank.
- R8: A host write whose address falls in the current front bank is ignored. A write to the back bank is stored and becomes visible after the next swap.
- R9: Several ready pulses within one frame cause only one swap.
- R10: The word address is bank*ROWS*COLS*3 + row*COLS*3 + channel. After reset, bank 0 is the front bank. Addresses at or beyond 2*ROWS*COLS*3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | $clog2(2*ROWS*COLS*3) | Host word address (bank, row, channel) |
| host_data_i | input | CH_BITS | Greyscale word to write |
| host_we_i | input | 1 | Host write enable |
| host_ready_i | input | 1 | Back bank complete; request a swap at the next frame start |
| sdo_o | output | 1 | Serial data to the driver chain |
| sclk_o | output | 1 | Shift clock to the driver chain |
| latch_o | output | 1 | Driver latch pulse |
| blank_o | output | 1 | Blanks every driver output |
| row_sel_o | output | ROWS | One-hot row select |

## Verification
The hardest case to reach is a ready pulse that arrives partway through a frame while host writes target the bank being shown. The stimulus waits for a chosen count of row latches and then sends two ready pulses in mid-frame. It also writes distinctive values into the front bank at rows that have not yet been shifted in that frame. Every row of the rest of that frame, and of the next frame, is then compared bit by bit against a model that swaps only at frame ends and drops writes to the front bank.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int RGB_CH = 3;

  typedef enum logic [2:0] {
    ST_FETCH0,
    ST_FETCH1,
    ST_SHIFT,
    ST_TAIL0,
    ST_TAIL1
  } stage_e;
endpackage

// File: rtl/lmr_seq.sv
module lmr_seq
  import lmr_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int CHANS   = 96,
  parameter int CH_BITS = 12,
  parameter int ROW_W   = 4,
  parameter int CHAN_W  = 7,
  parameter int BIT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output stage_e            stage_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [CHAN_W-1:0] rd_chan_o,
  output logic              load_o,
  output logic              shift_o,
  output logic              phase_o,
  output logic              frame_end_o
);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(CH_BITS - 1);
  localparam logic [CHAN_W-1:0] LAST_CH  = CHAN_W'(CHANS - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(ROWS - 1);

  // Mixed-radix counter: {row, stage, chan, bit, phase}
  stage_e            stage_q;
  logic              phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CHAN_W-1:0] chan_q;
  logic [ROW_W-1:0]  row_q;

  logic word_end, row_end, last_row;
  assign word_end = (bit_q == LAST_BIT);
  assign row_end  = (chan_q == LAST_CH);
  assign last_row = (row_q == LAST_ROW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_FETCH0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      chan_q  <= '0;
      row_q   <= '0;
    end else begin
      unique case (stage_q)
        ST_FETCH0: stage_q <= ST_FETCH1;
        ST_FETCH1: begin
          stage_q <= ST_SHIFT;
          phase_q <= 1'b0;
          bit_q   <= '0;
          chan_q  <= '0;
        end
        ST_SHIFT: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (word_end) begin
              bit_q <= '0;
              if (row_end) stage_q <= ST_TAIL0;
              else         chan_q  <= chan_q + 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_TAIL0: stage_q <= ST_TAIL1;
        ST_TAIL1: begin
          stage_q <= ST_FETCH0;
          row_q   <= last_row ? '0 : row_q + 1'b1;
        end
        default: stage_q <= ST_FETCH0;
      endcase
    end
  end

  assign stage_o     = stage_q;
  assign row_o       = row_q;
  assign phase_o     = phase_q;
  // read address runs one word ahead of the shifter
  assign rd_chan_o   = (stage_q == ST_FETCH0) ? '0 : chan_q + 1'b1;
  assign load_o      = (stage_q == ST_FETCH1) ||
                       ((stage_q == ST_SHIFT) && phase_q && word_end && !row_end);
  assign shift_o     = (stage_q == ST_SHIFT) && phase_q;
  assign frame_end_o = (stage_q == ST_TAIL1) && last_row;

  a_r3_tail_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_TAIL0) |-> ($past(stage_q) == ST_SHIFT));

  a_r5_row_moves_in_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_q != $past(row_q)) |-> ($past(stage_q) == ST_TAIL1));
endmodule

// File: rtl/lmr_bank.sv
module lmr_bank #(
  parameter int BANK_WORDS = 1536,
  parameter int AW         = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_end_i,
  input  logic          ready_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          wr_en_o,
  output logic          front_o
);
  logic front_q, pending_q, swap;
  logic host_bank, in_range;

  assign host_bank = ({1'b0, addr_i} >= (AW+1)'(BANK_WORDS));
  assign in_range  = ({1'b0, addr_i} <  (AW+1)'(2 * BANK_WORDS));
  assign swap      = frame_end_i && pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      front_q   <= front_q ^ swap;
      // a strobe in the swap cycle re-arms for the following frame
      pending_q <= ready_i || (pending_q && !swap);
    end
  end

  assign wr_en_o = we_i && in_range && (host_bank != front_q);
  assign front_o = front_q;

  a_r7_swap_at_frame_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (front_q != $past(front_q)) |-> $past(frame_end_i));

  a_r9_pending_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && pending_q && !ready_i) |=> !pending_q);

  a_r7_strobe_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> pending_q);
endmodule

// File: rtl/lmr_frame_ram.sv
module lmr_frame_ram #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 3072,
  parameter int AW    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lmr_out.sv
module lmr_out
  import lmr_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int CH_BITS = 12,
  parameter int ROW_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  stage_e             stage_i,
  input  logic               phase_i,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [CH_BITS-1:0] rd_data_i,
  output logic               sdo_o,
  output logic               sclk_o,
  output logic               latch_o,
  output logic               blank_o,
  output logic [ROWS-1:0]    row_sel_o
);
  localparam logic [ROWS-1:0] ROW_ONE = ROWS'(1);

  logic [CH_BITS-1:0] sh_q;
  logic [ROWS-1:0]    row_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= rd_data_i;
    else if (shift_i) sh_q <= {sh_q[CH_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  row_sel_q <= '0;
    else if (stage_i == ST_TAIL0) row_sel_q <= ROW_ONE << row_i;
  end

  assign sdo_o     = sh_q[CH_BITS-1];
  assign sclk_o    = (stage_i == ST_SHIFT) && phase_i;
  assign latch_o   = (stage_i == ST_TAIL0);
  assign blank_o   = (stage_i == ST_TAIL0) || (stage_i == ST_TAIL1);
  assign row_sel_o = row_sel_q;

  a_r3_latch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);

  a_r4_blank_on_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> blank_o);

  a_r4_row_change_blanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_sel_q != $past(row_sel_q)) |-> blank_o);

  a_r5_row_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_q));

  a_r6_sdo_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o));
endmodule

// File: rtl/led_matrix_refresh.sv
module led_matrix_refresh
  import lmr_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int COLS    = 32,
  parameter int CH_BITS = 12,
  localparam int CHANS      = COLS * RGB_CH,
  localparam int BANK_WORDS = ROWS * CHANS,
  localparam int DEPTH      = 2 * BANK_WORDS,
  localparam int AW         = $clog2(DEPTH),
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CHAN_W     = $clog2(CHANS + 1),
  localparam int BIT_W      = $clog2(CH_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      host_addr_i,
  input  logic [CH_BITS-1:0] host_data_i,
  input  logic               host_we_i,
  input  logic               host_ready_i,
  output logic               sdo_o,
  output logic               sclk_o,
  output logic               latch_o,
  output logic               blank_o,
  output logic [ROWS-1:0]    row_sel_o
);
  stage_e             stage;
  logic [ROW_W-1:0]   row;
  logic [CHAN_W-1:0]  rd_chan;
  logic               load, shift, phase, frame_end;
  logic               wr_en, front;
  logic [AW-1:0]      rd_addr;
  logic [CH_BITS-1:0] rd_data;

  lmr_seq #(
    .ROWS(ROWS), .CHANS(CHANS), .CH_BITS(CH_BITS),
    .ROW_W(ROW_W), .CHAN_W(CHAN_W), .BIT_W(BIT_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .stage_o(stage), .row_o(row), .rd_chan_o(rd_chan),
    .load_o(load), .shift_o(shift), .phase_o(phase), .frame_end_o(frame_end)
  );

  lmr_bank #(.BANK_WORDS(BANK_WORDS), .AW(AW)) u_bank (
    .clk_i, .rst_ni,
    .frame_end_i(frame_end), .ready_i(host_ready_i),
    .we_i(host_we_i), .addr_i(host_addr_i),
    .wr_en_o(wr_en), .front_o(front)
  );

  assign rd_addr = (front ? AW'(BANK_WORDS) : '0) + AW'(row) * AW'(CHANS) + AW'(rd_chan);

  lmr_frame_ram #(.WIDTH(CH_BITS), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(host_addr_i), .wdata_i(host_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  lmr_out #(.ROWS(ROWS), .CH_BITS(CH_BITS), .ROW_W(ROW_W)) u_out (
    .clk_i, .rst_ni,
    .stage_i(stage), .phase_i(phase), .load_i(load), .shift_i(shift),
    .row_i(row), .rd_data_i(rd_data),
    .sdo_o, .sclk_o, .latch_o, .blank_o, .row_sel_o
  );

  // R8: a store into the displayed bank would corrupt the scan
  a_r8_front_not_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (({1'b0, host_addr_i} >= (AW+1)'(BANK_WORDS)) == !front));
endmodule

// File: tb/led_matrix_refresh_tb_top.sv
module led_matrix_refresh_tb_top;
  localparam int ROWS     = 8;
  localparam int COLS     = 16;
  localparam int CH_BITS  = 12;
  localparam int CHANS    = COLS * 3;
  localparam int BANK     = ROWS * CHANS;
  localparam int AW       = $clog2(2 * BANK);
  localparam int ROW_BITS = CHANS * CH_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [CH_BITS-1:0] host_data = '0;
  logic host_we = 1'b0, host_ready = 1'b0;
  logic sdo, sclk, latch, blank;
  logic [ROWS-1:0] row_sel;

  always #5 clk = ~clk;

  led_matrix_refresh #(.ROWS(ROWS), .COLS(COLS), .CH_BITS(CH_BITS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(host_addr), .host_data_i(host_data),
    .host_we_i(host_we), .host_ready_i(host_ready),
    .sdo_o(sdo), .sclk_o(sclk), .latch_o(latch), .blank_o(blank), .row_sel_o(row_sel)
  );

  typedef struct { int bank; int row; bit known; } exp_t;
  exp_t exp_q[$];

  logic [CH_BITS-1:0] model [2][ROWS][CHANS];
  bit   known [2];
  int   model_front = 0;
  bit   model_pending = 1'b0;
  int   n_cmp = 0, n_bad = 0;
  int   latch_cnt = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CH_BITS-1:0] pat(int p, int r, int c);
    return CH_BITS'(p * 1237 + r * 97 + c * 13 + (r ^ c) + 5);
  endfunction

  task automatic push_frame();
    for (int r = 0; r < ROWS; r++) exp_q.push_back('{model_front, r, known[model_front]});
  endtask

  task automatic host_write(int b, int r, int c, logic [CH_BITS-1:0] d);
    @(negedge clk);
    host_addr = AW'(b * BANK + r * CHANS + c);
    host_data = d;
    host_we   = 1'b1;
    if (b != model_front) model[b][r][c] = d;  // R8: front bank writes dropped
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic fill_bank(int b, int p);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < CHANS; c++) host_write(b, r, c, pat(p, r, c));
    known[b] = 1'b1;
  endtask

  task automatic strobe();
    @(negedge clk) host_ready = 1'b1;
    @(negedge clk) host_ready = 1'b0;
    model_pending = 1'b1;
  endtask

  task automatic wait_latches(int n);
    while (latch_cnt < n) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic [ROW_BITS-1:0] bits, expv;
    bit   prev_sclk = 0, prev_sdo = 0, prev_latch = 0;
    logic [ROWS-1:0] prev_rs = '0;
    int   sidx = 0, last_rise = -10, bitcnt = 0, after_row = -1;
    exp_t it;
    bits = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      sidx++;
      if (after_row >= 0) begin
        check(row_sel == (ROWS'(1) << after_row), "R5", "row select after latch", row_sel, ROWS'(1) << after_row);
        check(blank == 1'b1, "R4", "blank after latch", blank, 1);
        after_row = -1;
      end
      if (row_sel != prev_rs) check(blank == 1'b1, "R4", "row change unblanked", blank, 1);
      if (sclk && prev_sclk) check(1'b0, "R6", "shift clock high two clocks", 1, 0);
      if (sclk && !prev_sclk) begin
        check(sdo == prev_sdo, "R6", "sdo moved at rising shift clock", sdo, prev_sdo);
        bits = {bits[ROW_BITS-2:0], sdo};
        bitcnt++;
        last_rise = sidx;
      end
      if (latch) begin
        if (prev_latch) check(1'b0, "R3", "latch longer than one clock", 1, 0);
        else if (exp_q.size() == 0) check(1'b0, "R5", "latch with no expected row", 1, 0);
        else begin
          it = exp_q.pop_front();
          check(bitcnt == ROW_BITS, "R2", "bits per row", bitcnt, ROW_BITS);
          check(sidx == last_rise + 1, "R3", "latch position after last bit", sidx - last_rise, 1);
          check(blank == 1'b1, "R4", "blank during latch", blank, 1);
          if (it.known) begin
            expv = '0;
            for (int c = 0; c < CHANS; c++)
              for (int b = CH_BITS - 1; b >= 0; b--) expv = {expv[ROW_BITS-2:0], model[it.bank][it.row][c][b]};
            if (bits === expv) check(1'b1, "R2", "row data", 0, 0);
            else begin
              for (int c = 0; c < CHANS; c++) begin
                if (bits[ROW_BITS-1-c*CH_BITS -: CH_BITS] !== expv[ROW_BITS-1-c*CH_BITS -: CH_BITS]) begin
                  check(1'b0, "R2/R7/R8/R9/R10", $sformatf("bank %0d row %0d chan %0d", it.bank, it.row, c),
                        bits[ROW_BITS-1-c*CH_BITS -: CH_BITS], expv[ROW_BITS-1-c*CH_BITS -: CH_BITS]);
                  break;
                end
              end
            end
          end
          bitcnt = 0;
          latch_cnt++;
          after_row = it.row;
          if (it.row == ROWS - 1) begin
            if (model_pending) begin
              model_front   = 1 - model_front;
              model_pending = 1'b0;
            end
            push_frame();
          end
        end
      end
      prev_sclk = sclk; prev_sdo = sdo; prev_latch = latch; prev_rs = row_sel;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", latch_cnt, 6 * ROWS);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    known[0] = 1'b0;
    known[1] = 1'b0;
    push_frame();  // frame 0: bank 0 never written, checked for structure only
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    check(latch == 1'b0, "R1", "latch in reset", latch, 0);
    check(sdo == 1'b0, "R1", "sdo in reset", sdo, 0);
    check(row_sel == '0, "R1", "row select in reset", row_sel, 0);
    rst_n = 1'b1;

    // R10: bank 1 is the back bank after reset
    fill_bank(1, 1);
    strobe();

    // frame 1 shows bank 1; front writes at rows not yet shown must not appear (R8)
    wait_latches(ROWS + 3);
    host_write(1, 5, CHANS - 1, 12'h0F0);
    host_write(1, 7, 10, 12'hABC);
    host_write(1, 0, 0, 12'h111);
    fill_bank(0, 2);

    // frame 2: no strobe yet, still bank 1 (R7); two strobes mid-frame -> one swap (R9)
    wait_latches(2 * ROWS + 4);
    strobe();
    strobe();

    // frame 3 shows bank 0; fill bank 1 and hit front bank row 6 (R8)
    wait_latches(3 * ROWS + 1);
    host_write(0, 6, 3, 12'h5A5);
    fill_bank(1, 3);

    // frame 4 still bank 0 (R9); strobe -> frame 5 bank 1
    wait_latches(4 * ROWS + 2);
    strobe();

    wait_latches(6 * ROWS);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule